// File: doc/BRIEF.md
# Link Power State Controller

This block keeps track of the logical power level of one serial link. It knows four levels: active (U0), an idle level that can be left quickly (U1), a deeper idle level that also lets the clock generator stop (U2), and suspend (U3). While the link is active and no traffic is seen, one inactivity timer moves the link to U1. A second timer, which runs only while the link sits in U1, moves it on to U2. The timer path never goes further than U2.

The attached device can ask for U1 or U2 at once, without waiting for the timers. Only a host command places the link in suspend. Traffic or a wake request on an idle level starts a return to U0. During that return a busy flag stays high for an exit time that software programs separately for each idle level. The link code then reads U0 again. Software sets the two timeouts and the three exit times through a small write-only register port.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `link_state` is 00 (U0) and `exit_busy`, `phy_pd_en` and `clk_gate_en` are 0. All five setting registers reset to 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next edge. The register is chosen by `cfg_addr`: 0 is the U1 timeout, 1 is the U2 timeout, 2, 3 and 4 are the exit times for U1, U2 and U3 (exit times take the low EXIT_W bits). The new value is used from the following cycle on.
- R3: In U0 with a nonzero U1 timeout T1, the link reads U1 after T1 edges in a row that see neither `link_act` nor `wake_req`. Any such activity restarts the count.
- R4: In U1 with a nonzero U2 timeout T2, the link reads U2 after T2 inactive edges in U1. The count starts at U1 entry and also restarts on activity.
- R5: A timeout value of 0 turns that timer off. The link then never reaches that level through the timer path.
- R6: `dev_u2_req` moves U0 or U1 to U2 at the next edge. `dev_u1_req` moves U0 to U1 at the next edge. Both take priority over the timers, and a U2 request wins over a U1 request.
- R7: `host_susp_cmd` moves U0, U1 or U2 to U3 at the next edge. In U0 it takes priority over every other input. U3 is never entered any other way.
- R8: Activity (`link_act` or `wake_req`) in U1, U2 or U3 makes `exit_busy` high for exactly E cycles, where E is the exit time of the level being left. During that time the state code holds and all other inputs are ignored. After it the link reads U0. If E is 0, the link reads U0 at the next edge with no busy cycle.
- R9: `phy_pd_en` is 1 exactly when the state is not U0 and no exit is in progress. `clk_gate_en` is 1 exactly when the state is U2 or U3 and no exit is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting register write strobe |
| cfg_addr | input | 3 | Setting register select |
| cfg_wdata | input | TMR_W | Write data |
| link_act | input | 1 | Traffic seen on the link this cycle |
| wake_req | input | 1 | Request to return to U0 |
| dev_u1_req | input | 1 | Device asks for U1 |
| dev_u2_req | input | 1 | Device asks for U2 |
| host_susp_cmd | input | 1 | Host commands suspend |
| link_state | output | 2 | Current level: 00 U0, 01 U1, 10 U2, 11 U3 |
| exit_busy | output | 1 | Return to U0 in progress |
| phy_pd_en | output | 1 | Transmitter and receiver may power down |
| clk_gate_en | output | 1 | Clock generation may stop |

## Verification
The assertions rely on reset being held for at least two clock edges before the first check. They also assume no input is X after reset. The assertions do not depend on how often requests arrive, because the block accepts any mix of them in any cycle. For that reason the random stimulus draws every request line independently each cycle, so conflicting requests appear together. The random stimulus also rewrites the settings while timers are running. The timeouts are kept small, so every level and every exit path is reached many times within a short run.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

    typedef enum logic [1:0] {
        LS_U0 = 2'b00,
        LS_U1 = 2'b01,
        LS_U2 = 2'b10,
        LS_U3 = 2'b11
    } lstate_e;

    localparam int NUM_TMR = 2;

    localparam logic [2:0] CFG_IDLE1 = 3'd0;
    localparam logic [2:0] CFG_IDLE2 = 3'd1;
    localparam logic [2:0] CFG_EXIT1 = 3'd2;
    localparam logic [2:0] CFG_EXIT2 = 3'd3;
    localparam logic [2:0] CFG_EXIT3 = 3'd4;

    typedef struct packed {
        lstate_e st;
        logic    busy;
    } fsm_stat_t;

    function automatic logic phy_may_sleep(input fsm_stat_t s);
        return (s.st != LS_U0) && !s.busy;
    endfunction

    function automatic logic clk_may_stop(input fsm_stat_t s);
        return ((s.st == LS_U2) || (s.st == LS_U3)) && !s.busy;
    endfunction

endpackage

// File: rtl/lpc_cfg_regs.sv
module lpc_cfg_regs #(
    parameter int TW = 16,
    parameter int EW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] idle1_to,
    output logic [TW-1:0] idle2_to,
    output logic [EW-1:0] exit1_len,
    output logic [EW-1:0] exit2_len,
    output logic [EW-1:0] exit3_len
);
    import link_pwr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle1_to  <= '0;
            idle2_to  <= '0;
            exit1_len <= '0;
            exit2_len <= '0;
            exit3_len <= '0;
        end else if (we) begin
            case (addr)
                CFG_IDLE1: idle1_to  <= wdata;
                CFG_IDLE2: idle2_to  <= wdata;
                CFG_EXIT1: exit1_len <= wdata[EW-1:0];
                CFG_EXIT2: exit2_len <= wdata[EW-1:0];
                CFG_EXIT3: exit3_len <= wdata[EW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lpc_idle_timer.sv
module lpc_idle_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;
    logic          armed;

    assign armed  = run && !clr && (limit != '0);
    assign expire = armed && (cnt_q >= limit - TW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (armed)
            cnt_q <= expire ? '0 : cnt_q + TW'(1);
    end

    // a zero limit must keep the timer silent
    AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (limit == '0) |-> !expire);  // R5
endmodule

// File: rtl/lpc_state_fsm.sv
module lpc_state_fsm
    import link_pwr_pkg::*;
#(
    parameter int EW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act,
    input  logic          host_susp,
    input  logic          dev_u1,
    input  logic          dev_u2,
    input  logic          exp1,
    input  logic          exp2,
    input  logic [EW-1:0] exit1_len,
    input  logic [EW-1:0] exit2_len,
    input  logic [EW-1:0] exit3_len,
    output fsm_stat_t     stat
);
    lstate_e       st_q, st_d;
    logic          busy_q, busy_d;
    logic [EW-1:0] ecnt_q, ecnt_d;
    logic [EW-1:0] exit_len;

    always_comb begin
        case (st_q)
            LS_U1:   exit_len = exit1_len;
            LS_U2:   exit_len = exit2_len;
            default: exit_len = exit3_len;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        busy_d = busy_q;
        ecnt_d = ecnt_q;
        if (busy_q) begin
            if (ecnt_q == '0) begin
                st_d   = LS_U0;
                busy_d = 1'b0;
            end else begin
                ecnt_d = ecnt_q - EW'(1);
            end
        end else begin
            unique case (st_q)
                LS_U0: begin
                    if (host_susp)   st_d = LS_U3;
                    else if (dev_u2) st_d = LS_U2;
                    else if (dev_u1) st_d = LS_U1;
                    else if (exp1)   st_d = LS_U1;
                end
                LS_U1, LS_U2, LS_U3: begin
                    if (act) begin
                        if (exit_len == '0) begin
                            st_d = LS_U0;
                        end else begin
                            busy_d = 1'b1;
                            ecnt_d = exit_len - EW'(1);
                        end
                    end else if (host_susp && (st_q != LS_U3)) begin
                        st_d = LS_U3;
                    end else if ((st_q == LS_U1) && (dev_u2 || exp2)) begin
                        st_d = LS_U2;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LS_U0;
            busy_q <= 1'b0;
            ecnt_q <= '0;
        end else begin
            st_q   <= st_d;
            busy_q <= busy_d;
            ecnt_q <= ecnt_d;
        end
    end

    assign stat.st   = st_q;
    assign stat.busy = busy_q;

    AST_U3_HOST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (st_q == LS_U3 && $past(st_q) != LS_U3) |-> $past(host_susp));  // R7
    AST_NO_TIMER_SKIP: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == LS_U0 && st_q == LS_U2) |-> $past(dev_u2));  // R6
    AST_EXIT_LANDS_U0: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (st_q == LS_U0));  // R8
    AST_EXIT_HOLDS_CODE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(st_q));  // R8
    AST_BUSY_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (st_q != LS_U0));  // R8
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import link_pwr_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int EXIT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [TMR_W-1:0] cfg_wdata,
    input  logic             link_act,
    input  logic             wake_req,
    input  logic             dev_u1_req,
    input  logic             dev_u2_req,
    input  logic             host_susp_cmd,
    output logic [1:0]       link_state,
    output logic             exit_busy,
    output logic             phy_pd_en,
    output logic             clk_gate_en
);
    logic [TMR_W-1:0]  idle_to [NUM_TMR];
    logic [EXIT_W-1:0] exit1_len, exit2_len, exit3_len;
    logic [NUM_TMR-1:0] tmr_run, tmr_clr, tmr_exp;
    lstate_e           tmr_home [NUM_TMR];
    fsm_stat_t         stat;
    logic              act;

    assign act = link_act || wake_req;

    lpc_cfg_regs #(.TW(TMR_W), .EW(EXIT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .idle1_to  (idle_to[0]),
        .idle2_to  (idle_to[1]),
        .exit1_len (exit1_len),
        .exit2_len (exit2_len),
        .exit3_len (exit3_len)
    );

    assign tmr_home[0] = LS_U0;
    assign tmr_home[1] = LS_U1;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic at_home;
        assign at_home    = (stat.st == tmr_home[g]) && !stat.busy;
        assign tmr_run[g] = at_home && !act;
        assign tmr_clr[g] = !at_home || act;

        lpc_idle_timer #(.TW(TMR_W)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .run    (tmr_run[g]),
            .clr    (tmr_clr[g]),
            .limit  (idle_to[g]),
            .expire (tmr_exp[g])
        );
    end

    lpc_state_fsm #(.EW(EXIT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .host_susp (host_susp_cmd),
        .dev_u1    (dev_u1_req),
        .dev_u2    (dev_u2_req),
        .exp1      (tmr_exp[0]),
        .exp2      (tmr_exp[1]),
        .exit1_len (exit1_len),
        .exit2_len (exit2_len),
        .exit3_len (exit3_len),
        .stat      (stat)
    );

    assign link_state  = stat.st;
    assign exit_busy   = stat.busy;
    assign phy_pd_en   = phy_may_sleep(stat);
    assign clk_gate_en = clk_may_stop(stat);

    AST_GATE_IMPLIES_PD: assert property (@(posedge clk) disable iff (rst)
        clk_gate_en |-> phy_pd_en);  // R9
    AST_AWAKE_WHILE_EXIT: assert property (@(posedge clk) disable iff (rst)
        exit_busy |-> (!phy_pd_en && !clk_gate_en));  // R9
    AST_TIMERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tmr_run));  // R4
endmodule

// File: tb/link_pwr_ctrl_tb_top.sv
module link_pwr_ctrl_tb_top;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [2:0]    cfg_addr;
    logic [TW-1:0] cfg_wdata;
    logic          link_act, wake_req, dev_u1_req, dev_u2_req, host_susp_cmd;
    logic [1:0]    link_state;
    logic          exit_busy, phy_pd_en, clk_gate_en;

    always #10 clk = ~clk;  // 50 MHz

    link_pwr_ctrl #(.TMR_W(TW), .EXIT_W(12)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .link_act(link_act), .wake_req(wake_req),
        .dev_u1_req(dev_u1_req), .dev_u2_req(dev_u2_req),
        .host_susp_cmd(host_susp_cmd), .link_state(link_state),
        .exit_busy(exit_busy), .phy_pd_en(phy_pd_en), .clk_gate_en(clk_gate_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_st, m_busy, m_ecnt, m_c1, m_c2;
    int m_to1, m_to2, m_ex1, m_ex2, m_ex3;

    function automatic logic [4:0] exp_vec();
        logic pd, gt;
        pd = (m_st != 0) && (m_busy == 0);
        gt = (m_st >= 2) && (m_busy == 0);
        return {m_st[1:0], (m_busy != 0), pd, gt};
    endfunction

    function automatic logic [4:0] dut_vec();
        return {link_state, exit_busy, phy_pd_en, clk_gate_en};
    endfunction

    task automatic check(input logic [4:0] act_v, input logic [4:0] exp_v, input string tag);
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got {st,busy,pd,gate}=%b expected %b at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic m_reset();
        m_st = 0; m_busy = 0; m_ecnt = 0; m_c1 = 0; m_c2 = 0;
        m_to1 = 0; m_to2 = 0; m_ex1 = 0; m_ex2 = 0; m_ex3 = 0;
    endtask

    task automatic m_step(input bit a, input bit h, input bit d1, input bit d2,
                          input bit we, input int ad, input int wd);
        bit fire;
        int e;
        fire = 0;
        if (m_busy != 0) begin
            if (m_ecnt == 0) begin m_st = 0; m_busy = 0; end
            else m_ecnt--;
            m_c1 = 0; m_c2 = 0;
        end else if (m_st == 0) begin
            m_c2 = 0;
            if (a) m_c1 = 0;
            else if (m_to1 != 0) begin
                if (m_c1 + 1 >= m_to1) begin fire = 1; m_c1 = 0; end
                else m_c1++;
            end
            if (h) m_st = 3;
            else if (d2) m_st = 2;
            else if (d1 || fire) m_st = 1;
        end else begin
            m_c1 = 0;
            if (m_st == 1 && !a) begin
                if (m_to2 != 0) begin
                    if (m_c2 + 1 >= m_to2) begin fire = 1; m_c2 = 0; end
                    else m_c2++;
                end
            end else m_c2 = 0;
            if (a) begin
                e = (m_st == 1) ? m_ex1 : (m_st == 2) ? m_ex2 : m_ex3;
                if (e == 0) m_st = 0;
                else begin m_busy = 1; m_ecnt = e - 1; end
            end else if (h && m_st != 3) m_st = 3;
            else if (m_st == 1 && (d2 || fire)) m_st = 2;
        end
        if (we) begin
            case (ad)
                0: m_to1 = wd;
                1: m_to2 = wd;
                2: m_ex1 = wd % 4096;
                3: m_ex2 = wd % 4096;
                4: m_ex3 = wd % 4096;
                default: ;
            endcase
        end
    endtask

    // one cycle: drive at negedge, model at the edge, compare at next negedge
    task automatic cyc(input bit a, input bit w, input bit h, input bit d1, input bit d2,
                       input bit we, input int ad, input int wd, input string tag);
        link_act = a; wake_req = w; host_susp_cmd = h;
        dev_u1_req = d1; dev_u2_req = d2;
        cfg_we = we; cfg_addr = ad[2:0]; cfg_wdata = wd[TW-1:0];
        @(posedge clk);
        m_step(a || w, h, d1, d2, we, ad, wd);
        @(negedge clk);
        check(dut_vec(), exp_vec(), tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int ad, input int wd);
        cyc(0, 0, 0, 0, 0, 1, ad, wd, "R2");
    endtask

    initial begin
        rst = 1'b1;
        link_act = 0; wake_req = 0; host_susp_cmd = 0;
        dev_u1_req = 0; dev_u2_req = 0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        m_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(dut_vec(), 5'b00000, "R1 during reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(dut_vec(), 5'b00000, "R1 after reset");
        // timers reset to zero: long idle stays in U0
        idle(30, "R1 R5");
        check(dut_vec(), 5'b00000, "R5 disabled after reset");

        // settings (R2)
        wr(2, 2); wr(3, 5); wr(4, 7); wr(1, 3);
        wr(0, 4);
        // R3: four idle edges reach U1, three do not
        idle(3, "R3");
        check(dut_vec(), 5'b00000, "R3 before timeout");
        idle(1, "R3");
        check(dut_vec(), 5'b01010, "R3 R9 at timeout");
        // R4: three idle edges in U1 reach U2
        idle(2, "R4");
        check(dut_vec(), 5'b01010, "R4 before timeout");
        idle(1, "R4");
        check(dut_vec(), 5'b10011, "R4 R9 at timeout");
        // R8: wake from U2, five busy cycles
        cyc(0, 1, 0, 0, 0, 0, 0, 0, "R8");
        check(dut_vec(), 5'b10100, "R8 exit started");
        cyc(0, 0, 1, 0, 1, 0, 0, 0, "R8 inputs ignored");
        idle(3, "R8");
        check(dut_vec(), 5'b10100, "R8 last busy cycle");
        idle(1, "R8");
        check(dut_vec(), 5'b00000, "R8 back in U0");
        // R3: activity restarts the count
        idle(2, "R3"); cyc(1, 0, 0, 0, 0, 0, 0, 0, "R3"); idle(3, "R3");
        check(dut_vec(), 5'b00000, "R3 restart after activity");
        idle(1, "R3");
        check(dut_vec(), 5'b01010, "R3 after restart");
        // R8: exit from U1 takes two cycles
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8"); idle(1, "R8");
        check(dut_vec(), 5'b01100, "R8 U1 exit busy");
        idle(1, "R8");
        check(dut_vec(), 5'b00000, "R8 U1 exit done");
        // R5: zero U1 timeout
        wr(0, 0);
        idle(40, "R5");
        check(dut_vec(), 5'b00000, "R5 zero timeout");
        // R6: device requests
        cyc(0, 0, 0, 1, 1, 0, 0, 0, "R6 u2 wins");
        check(dut_vec(), 5'b10011, "R6 u2 over u1");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8"); idle(5, "R8");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, "R6");
        check(dut_vec(), 5'b01010, "R6 u1 request");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, "R6");
        check(dut_vec(), 5'b10011, "R6 u1 to u2");
        // R7: host suspend from U2, then exit 7 cycles
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R7");
        check(dut_vec(), 5'b11011, "R7 U2 to U3");
        idle(20, "R7 stays");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8"); idle(6, "R8");
        check(dut_vec(), 5'b11100, "R8 U3 exit busy");
        idle(1, "R8");
        check(dut_vec(), 5'b00000, "R8 U3 exit done");
        // R7: host beats device and activity in U0
        cyc(1, 0, 1, 1, 1, 0, 0, 0, "R7 priority");
        check(dut_vec(), 5'b11011, "R7 priority in U0");
        // R8: zero exit time
        wr(4, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8 zero exit");
        check(dut_vec(), 5'b00000, "R8 zero exit immediate");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit we;
            int ad, wd;
            we = ($urandom_range(99) < 4);
            ad = $urandom_range(4);
            wd = (ad < 2) ? $urandom_range(10) : $urandom_range(6);
            cyc($urandom_range(99) < 7, $urandom_range(99) < 2, $urandom_range(99) < 1,
                $urandom_range(99) < 2, $urandom_range(99) < 1, we, ad, wd,
                "random R3 R4 R6 R7 R8 R9");
        end
        done = 1;
    end

    initial begin
        void'($urandom(32'h1d5e_0a77));
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: got hung run expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule